// File: doc/BRIEF.md
# Instruction-Driven Fixed-Point Matrix Multiply Engine

This block computes the product C = A x B of two small square matrices of signed Q8.8 values. It does not hardwire the loop nest. It executes a precompiled list of three-address instructions, each either a multiply or an add. All instructions work on one shared operand store that holds the A, B and C entries and a single scratch slot. Software, or a testbench, fills the operand store and the instruction store through two valid/ready load ports, then pulses `start` with the program length. After the last result has been written back, `done` is raised and the C entries can be read through a plain combinational read port.

The front end is an in-order controller. Each cycle it looks at the next instruction and hands it to the lowest-numbered free unit of the matching kind, provided a per-slot scoreboard shows the operands are ready. The pool has `NMUL` multipliers and `NADD` adders. Each unit holds one operation at a time. Any unit may read or write any slot. Results return through a single write port that serves one unit per cycle.

Back-pressure on both load ports is simple: `*_ready` is high whenever the engine is idle and low for the whole of a run. A word is stored only on a cycle where valid and ready are both high. A source must keep its word stable until that handshake happens.

Top module: `mm_engine`

## Requirements
- R1: While a run is in progress, `ld_ready` and `ins_ready` are low and words offered on either port are not stored. While idle, both are high and a word is stored on the clock edge where valid is high.
- R2: An instruction word is `{op, dst, src1, src2}`, most significant first. `op` is one bit: 0 = multiply, 1 = add. Each address field is AW bits wide. Entries 0 to `prog_len-1` run in order.
- R3: A multiply forms the full signed product and shifts it right arithmetically by 8, which rounds toward minus infinity. Results above 0x7FFF or below 0x8000 are clamped to those limits.
- R4: An add produces the signed sum clamped to the range 0x8000 to 0x7FFF.
- R5: An instruction issues only when both sources have been written since the start (or loaded) and no issued write to either source or to its destination is still outstanding. Final results therefore equal those of strictly sequential execution.
- R6: A multiply writes back 3 cycles after it issues and an add 1 cycle after it issues, unless it loses arbitration. Only one result is written per cycle. The lowest unit index wins, and multipliers take indices 0 to NMUL-1, below the adders.
- R7: `done` rises one cycle after the final writeback and stays high until the next accepted `start`. A `start` seen while running is ignored.
- R8: With `prog_len` = 0, `done` rises one cycle after the start edge.
- R9: `rd_data` shows C(i,j) combinationally for `rd_idx` = i*N + j.
- R10: The operand slots are laid out as follows: A(i,k) at i*N+k, B(k,j) at N*N+k*N+j, C(i,j) at 2*N*N+i*N+j, and the scratch slot at 3*N*N. A start marks the C and scratch slots as unwritten and leaves A and B as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Operand word offered |
| ld_ready | output | 1 | Operand port can accept a word (engine idle) |
| ld_addr | input | AW | Operand slot address |
| ld_data | input | DW | Operand value, Q8.8 |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Instruction port can accept a word (engine idle) |
| ins_addr | input | IAW | Instruction store entry |
| ins_word | input | IW | Encoded instruction |
| start | input | 1 | Begin a run when idle |
| prog_len | input | PCW | Number of instructions in the run |
| rd_idx | input | CIW | Index of the C entry to read |
| rd_data | output | DW | C entry at `rd_idx` |
| done | output | 1 | Run complete |

## Verification
Two events can fall in the same cycle. The first is two finished units competing for the one write port. The second is the writeback of one result alongside the issue of a later instruction. The bench provokes both with a short program of two independent multiplies followed by an independent add, timed so that the add finishes in the same cycle as the first multiply and then has to wait behind the second. It judges the outcome by the exact cycle at which `done` rises (seven edges after start) and by the three results. During the same run it also offers a competing `start` and an operand write, and checks that both leave the results and the timing untouched.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_ADD = 1'b1
  } mm_op_e;
endpackage

// File: rtl/mm_alu_unit.sv
module mm_alu_unit #(
  parameter int DW     = 16,
  parameter int FRAC   = 8,
  parameter int AW     = 4,
  parameter int LAT    = 3,
  parameter bit IS_MUL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [AW-1:0] dst_in,
  input  logic          gnt,
  output logic          occ,
  output logic          req,
  output logic [DW-1:0] res,
  output logic [AW-1:0] dst_out
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [CW-1:0] cnt;
  logic [DW-1:0] a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ     <= 1'b0;
      cnt     <= '0;
      a_q     <= '0;
      b_q     <= '0;
      dst_out <= '0;
    end else if (go) begin
      occ     <= 1'b1;
      cnt     <= CW'(LAT - 1);
      a_q     <= opa;
      b_q     <= opb;
      dst_out <= dst_in;
    end else if (occ) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      else if (gnt)  occ <= 1'b0;
    end
  end

  assign req = occ && (cnt == '0);

  generate
    if (IS_MUL) begin : g_mul
      logic signed [2*DW-1:0] prod, shd;
      logic ov_pos, ov_neg;
      always_comb begin
        prod   = $signed(a_q) * $signed(b_q);
        shd    = prod >>> FRAC;
        ov_pos = !shd[2*DW-1] && (|shd[2*DW-2:DW-1]);
        ov_neg = shd[2*DW-1] && !(&shd[2*DW-2:DW-1]);
        if (ov_pos)      res = SMAX;
        else if (ov_neg) res = SMIN;
        else             res = shd[DW-1:0];
      end
    end else begin : g_add
      logic [DW:0] sum;
      always_comb begin
        sum = {a_q[DW-1], a_q} + {b_q[DW-1], b_q};
        if (sum[DW] != sum[DW-1]) res = sum[DW] ? SMIN : SMAX;
        else                      res = sum[DW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/mm_wb_arb.sv
module mm_wb_arb #(
  parameter int NU = 3
) (
  input  logic [NU-1:0] req,
  output logic [NU-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int u = 0; u < NU; u++) begin
      if (req[u] && (gnt == '0)) gnt[u] = 1'b1;
    end
  end
endmodule

// File: rtl/mm_engine.sv
module mm_engine #(
  parameter int N       = 2,
  parameter int DW      = 16,
  parameter int FRAC    = 8,
  parameter int NMUL    = 2,
  parameter int NADD    = 1,
  parameter int MUL_LAT = 3,
  parameter int ADD_LAT = 1,
  parameter int IDEPTH  = 32,
  localparam int NE     = N * N,
  localparam int DEPTH  = 3 * NE + 1,
  localparam int AW     = $clog2(DEPTH),
  localparam int SLOTS  = 1 << AW,
  localparam int IW     = 1 + 3 * AW,
  localparam int IAW    = $clog2(IDEPTH),
  localparam int PCW    = $clog2(IDEPTH + 1),
  localparam int CIW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int NU     = NMUL + NADD,
  localparam int UIW    = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [AW-1:0]  ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic           ins_valid,
  output logic           ins_ready,
  input  logic [IAW-1:0] ins_addr,
  input  logic [IW-1:0]  ins_word,
  input  logic           start,
  input  logic [PCW-1:0] prog_len,
  input  logic [CIW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic           done
);
  import mm_pkg::*;

  logic [DW-1:0]    mem  [SLOTS];
  logic [IW-1:0]    imem [IDEPTH];
  logic [SLOTS-1:0] vld, pend;
  logic             running;
  logic [PCW-1:0]   pc, len_q;

  // decode of the instruction at the program counter
  logic [IW-1:0] cur;
  mm_op_e        op;
  logic [AW-1:0] dst, s1, s2;
  assign cur = imem[pc[IAW-1:0]];
  assign op  = mm_op_e'(cur[IW-1]);
  assign dst = cur[3*AW-1:2*AW];
  assign s1  = cur[2*AW-1:AW];
  assign s2  = cur[AW-1:0];

  // unit pool
  logic [NU-1:0] occ, req, gnt, go;
  logic [DW-1:0] u_res [NU];
  logic [AW-1:0] u_dst [NU];

  logic           found;
  logic [UIW-1:0] pick;
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int u = 0; u < NU; u++) begin
      if (!found && !occ[u] && ((u < NMUL) == (op == OP_MUL))) begin
        found = 1'b1;
        pick  = UIW'(u);
      end
    end
  end

  logic src_rdy, issue;
  assign src_rdy = vld[s1] && !pend[s1] && vld[s2] && !pend[s2];
  assign issue   = running && (pc < len_q) && src_rdy && !pend[dst] && found;

  always_comb begin
    for (int u = 0; u < NU; u++) go[u] = issue && (pick == UIW'(u));
  end

  genvar g;
  generate
    for (g = 0; g < NU; g++) begin : g_unit
      mm_alu_unit #(
        .DW(DW), .FRAC(FRAC), .AW(AW),
        .LAT((g < NMUL) ? MUL_LAT : ADD_LAT),
        .IS_MUL(g < NMUL)
      ) u_alu (
        .clk(clk), .rst_n(rst_n), .go(go[g]),
        .opa(mem[s1]), .opb(mem[s2]), .dst_in(dst),
        .gnt(gnt[g]), .occ(occ[g]), .req(req[g]),
        .res(u_res[g]), .dst_out(u_dst[g])
      );
    end
  endgenerate

  mm_wb_arb #(.NU(NU)) u_arb (.req(req), .gnt(gnt));

  logic          wb_en;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  always_comb begin
    wb_addr = '0;
    wb_data = '0;
    for (int u = 0; u < NU; u++) begin
      if (gnt[u]) begin
        wb_addr = u_dst[u];
        wb_data = u_res[u];
      end
    end
  end
  assign wb_en = |gnt;

  assign ld_ready  = !running;
  assign ins_ready = !running;

  // control and scoreboard
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      done    <= 1'b0;
      pc      <= '0;
      len_q   <= '0;
      vld     <= '0;
      pend    <= '0;
    end else begin
      if (ld_valid && ld_ready) vld[ld_addr] <= 1'b1;
      if (!running) begin
        if (start) begin
          running <= 1'b1;
          done    <= 1'b0;
          pc      <= '0;
          len_q   <= prog_len;
          for (int a = 2 * NE; a < SLOTS; a++) vld[a] <= 1'b0;
        end
      end else begin
        if (issue) begin
          pc        <= pc + 1'b1;
          pend[dst] <= 1'b1;
        end
        if (wb_en) begin
          pend[wb_addr] <= 1'b0;
          vld[wb_addr]  <= 1'b1;
        end
        if ((pc == len_q) && (occ == '0)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // storage
  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) mem[ld_addr] <= ld_data;
    if (wb_en) mem[wb_addr] <= wb_data;
    if (ins_valid && ins_ready) imem[ins_addr] <= ins_word;
  end

  logic [AW-1:0] rd_addr;
  assign rd_addr = AW'(2 * NE) + AW'(rd_idx);
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mm_engine_chk.sv
module mm_engine_chk #(
  parameter int AW    = 4,
  parameter int NU    = 3,
  parameter int PCW   = 6,
  parameter int SLOTS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             running,
  input logic             done,
  input logic             wb_en,
  input logic [AW-1:0]    wb_addr,
  input logic [SLOTS-1:0] pend,
  input logic [NU-1:0]    gnt,
  input logic [PCW-1:0]   pc,
  input logic [PCW-1:0]   len_q
);
  // R6
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R5
  wb_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> pend[wb_addr]);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !running);

  // R7
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> running);

  // R2
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pc <= len_q));

  // R6
  wb_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> running);
endmodule

bind mm_engine mm_engine_chk #(
  .AW(AW), .NU(NU), .PCW(PCW), .SLOTS(SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running), .done(done),
  .wb_en(wb_en), .wb_addr(wb_addr), .pend(pend), .gnt(gnt),
  .pc(pc), .len_q(len_q)
);

// File: tb/tb_mm_engine.sv
module tb_mm_engine;
  localparam int AW = 4, IW = 13, IAW = 5, PCW = 6, CIW = 2;
  localparam int CB = 8, TMP = 12;

  // stimulus vectors: A(0,0) A(0,1) A(1,0) A(1,1) B(0,0) B(0,1) B(1,0) B(1,1)
  localparam logic [15:0] VEC [4][8] = '{
    '{16'h0100, 16'h0000, 16'h0000, 16'h0100, 16'h0200, 16'h0180, 16'hFF00, 16'h0040},
    '{16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0080, 16'hFF80, 16'h0100, 16'h0040},
    '{16'hFE00, 16'h8000, 16'h7FFF, 16'h0001, 16'h0300, 16'h0100, 16'h7FFF, 16'hFFFF},
    '{16'h4000, 16'h4000, 16'hC000, 16'h7000, 16'h4000, 16'h7000, 16'h4000, 16'h7000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic ins_valid = 1'b0, ins_ready;
  logic [IAW-1:0] ins_addr = '0;
  logic [IW-1:0] ins_word = '0;
  logic start = 1'b0;
  logic [PCW-1:0] prog_len = '0;
  logic [CIW-1:0] rd_idx = '0;
  logic [15:0] rd_data;
  logic done;

  int total = 0, bad = 0, cyc = 0;

  always #5 clk = ~clk;

  mm_engine dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_addr(ins_addr), .ins_word(ins_word),
    .start(start), .prog_len(prog_len), .rd_idx(rd_idx), .rd_data(rd_data), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] m_mul(logic [15:0] a, logic [15:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    p = p >>> 8;
    if (p > 32767) return 16'h7FFF;
    if (p < -32768) return 16'h8000;
    return p[15:0];
  endfunction

  function automatic logic [15:0] m_add(logic [15:0] a, logic [15:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s > 32767) return 16'h7FFF;
    if (s < -32768) return 16'h8000;
    return s[15:0];
  endfunction

  function automatic logic [IW-1:0] enc(bit op, int d, int a, int b);
    return {op, 4'(d), 4'(a), 4'(b)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put_op(input int a, input logic [15:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 4'(a); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic put_ins(input int a, input logic [IW-1:0] w);
    @(negedge clk);
    ins_valid = 1'b1; ins_addr = 5'(a); ins_word = w;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic read_c(input int idx, output logic [15:0] v);
    @(negedge clk);
    rd_idx = 2'(idx);
    #1 v = rd_data;
  endtask

  task automatic run(input int len, input bit poke, output int cnt);
    @(negedge clk);
    prog_len = 6'(len); start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(posedge clk);
      #1 cnt++;
      if (poke && cnt == 1) begin
        // R1 R7: offered while busy, must be refused / ignored
        chk("R1 ld_ready low while running", {15'd0, ld_ready}, 16'd0);
        ld_valid = 1'b1; ld_addr = 4'(CB + 3); ld_data = 16'h5555;
        start = 1'b1; prog_len = '0;
      end
      if (poke && cnt == 2) begin
        ld_valid = 1'b0; start = 1'b0;
      end
    end
    if (cnt >= 2000) chk("run timeout", 16'(cnt), 16'd0);
  endtask

  initial begin
    int cnt;
    logic [15:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 done after reset", {15'd0, done}, 16'd0);
    chk("R1 ld_ready idle", {15'd0, ld_ready}, 16'd1);
    chk("R1 ins_ready idle", {15'd0, ins_ready}, 16'd1);

    // matrix program, R10 slot layout, R2 encoding, R5 multiply/scratch/add chain
    begin
      int n = 0;
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          put_ins(n, enc(1'b0, CB + i*2 + j, i*2, 4 + j)); n++;
          put_ins(n, enc(1'b0, TMP, i*2 + 1, 4 + 2 + j)); n++;
          put_ins(n, enc(1'b1, CB + i*2 + j, CB + i*2 + j, TMP)); n++;
        end
    end

    for (int t = 0; t < 4; t++) begin
      for (int s = 0; s < 8; s++) put_op(s, VEC[t][s]);
      run(12, 1'b0, cnt);
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          e = m_add(m_mul(VEC[t][i*2], VEC[t][4 + j]), m_mul(VEC[t][i*2 + 1], VEC[t][6 + j]));
          read_c(i*2 + j, v);
          chk($sformatf("R2 R3 R4 R5 R9 R10 vec%0d c%0d%0d", t, i, j), v, e);
        end
    end

    // R8: empty program
    run(0, 1'b0, cnt);
    chk("R8 empty program done cycle", 16'(cnt), 16'd1);

    // R4 R6: single add, positive saturation and add latency
    put_op(0, 16'h7000); put_op(4, 16'h2000);
    put_ins(0, enc(1'b1, CB, 0, 4));
    run(1, 1'b0, cnt);
    chk("R6 add latency done cycle", 16'(cnt), 16'd3);
    read_c(0, v); chk("R4 add saturates high", v, 16'h7FFF);
    put_op(0, 16'h8000); put_op(4, 16'hFF00);
    run(1, 1'b0, cnt);
    read_c(0, v); chk("R4 add saturates low", v, 16'h8000);

    // R3 R6: single multiply, floor rounding and multiply latency
    put_op(0, 16'hFFFF); put_op(4, 16'h0080);
    put_ins(0, enc(1'b0, CB, 0, 4));
    run(1, 1'b0, cnt);
    chk("R6 mul latency done cycle", 16'(cnt), 16'd5);
    read_c(0, v); chk("R3 mul rounds toward minus inf", v, 16'hFFFF);
    put_op(0, 16'h8000); put_op(4, 16'h8000);
    run(1, 1'b0, cnt);
    read_c(0, v); chk("R3 mul saturates high", v, 16'h7FFF);

    // R6 R7 R1: write-port collision, ignored start and load during run
    put_op(CB + 3, 16'h1234);
    put_op(0, 16'h0200); put_op(4, 16'h0300);
    put_op(1, 16'h0180); put_op(5, 16'hFE00);
    put_op(2, 16'h0100); put_op(6, 16'h0080);
    put_ins(0, enc(1'b0, CB, 0, 4));
    put_ins(1, enc(1'b0, CB + 1, 1, 5));
    put_ins(2, enc(1'b1, CB + 2, 2, 6));
    run(3, 1'b1, cnt);
    chk("R6 R7 collision done cycle", 16'(cnt), 16'd7);
    read_c(0, v); chk("R6 collision c0", v, 16'h0600);
    read_c(1, v); chk("R6 collision c1", v, 16'hFD00);
    read_c(2, v); chk("R6 collision c2", v, 16'h0180);
    read_c(3, v); chk("R1 load during run ignored", v, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R7 done holds", {15'd0, done}, 16'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule